// File: doc/BRIEF.md
# Socket Status-Change Interrupt Register

This block holds the status-change flags for one removable-card socket and raises an interrupt request to the host when any of them is set. It watches six asynchronous card pins: two card-detect lines, a ready line, a battery-warning line, a battery-dead/status-change line and a ring-indicate line. Each pin passes through a two-stage synchronizer, and an edge detector then turns it into a one-cycle event. Each of the four flags has its own enable input. A disabled flag is held at zero.

Host software reads the register through a plain strobe interface. A run-time mode input chooses how flags are cleared. In clear-on-read mode, a read returns the current flags and clears all of them on the following edge. In write-one-to-clear mode, each 1 in the write data clears the matching flag. A card-type input masks the ready and battery-warning flags for I/O cards. A ring option moves flag 0 from the battery-dead pin to the ring-indicate pin.

The flags have two reset sources. A global reset always clears them. A bus reset clears them only while power-management-event context is off. Both reset paths assert asynchronously and release synchronously to the clock.

Top module: `sock_chg_reg`

## Requirements
- R1: `rd_data[7:4]` always reads 0. The flag positions are: bit 3 card-detect change, bit 2 ready change, bit 1 battery warning, bit 0 battery-dead/status change (or ring). `src_en[i]` enables flag bit i.
- R2: While `src_en[i]` is 0, flag i reads 0 and cannot set. A flag that was set is cleared on the first edge at which its enable is 0, and it stays clear when the enable returns.
- R3: Flag 3 sets on any change, rising or falling, of either `cdet_in[0]` or `cdet_in[1]`.
- R4: Flag 2 sets on a rising transition of `rdy_in` only. A falling transition leaves it at 0.
- R5: While `io_card` is 1, flags 2 and 1 read 0, whatever `rdy_in` and `bwarn_in` do.
- R6: With `clr_mode` = 0 (clear-on-read), `rd_data` during an `rd_stb` cycle shows the flags held before the clear, and all flags read 0 after that edge. Writes have no effect in this mode.
- R7: With `clr_mode` = 1 (write-one-to-clear), a `wr_stb` clears each flag whose `wr_data` bit is 1. A 0 bit leaves the flag unchanged, and reads do not clear.
- R8: With `ring_mode` = 0, flag 0 sets on a rising transition of `bdead_in`. With `ring_mode` = 1, flag 0 sets on a rising transition of `ring_in`, and `bdead_in` has no effect.
- R9: All flags reset to 0. With `pme_en` = 1 only `glob_rst_n` low clears them. With `pme_en` = 0, either `glob_rst_n` low or `bus_rst_n` low clears them.
- R10: An event arriving in the same cycle as a clear of its flag wins: the flag is 1 after that edge.
- R11: `irq` is 1 exactly when at least one flag is set. It drops in the cycle after the last flag is cleared.
- R12: A pin change driven between two clock edges is visible as a set flag after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| glob_rst_n | input | 1 | Global reset, active low, asynchronous |
| bus_rst_n | input | 1 | Bus reset, active low. Clears flags only while `pme_en` is 0 |
| pme_en | input | 1 | Power-management-event context enabled |
| clr_mode | input | 1 | 0 = clear-on-read, 1 = write-one-to-clear |
| io_card | input | 1 | 1 = I/O card inserted, 0 = memory card |
| ring_mode | input | 1 | 1 = flag 0 follows the ring-indicate pin |
| src_en | input | 4 | Per-flag enables, bit i for flag i |
| cdet_in | input | 2 | Card-detect pins (asynchronous) |
| rdy_in | input | 1 | Ready pin (asynchronous) |
| bwarn_in | input | 1 | Battery-warning pin (asynchronous) |
| bdead_in | input | 1 | Battery-dead / status-change pin (asynchronous) |
| ring_in | input | 1 | Ring-indicate pin (asynchronous) |
| rd_stb | input | 1 | Register read strobe |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check on every cycle that the reserved bits stay zero and that a disabled or I/O-masked flag reads zero. They also check that a clear-on-read strobe without a coincident event leaves the flags and `irq` at zero, that a write-one-to-clear removes the flags it names, and that a flag receiving an event is always set on the next edge, even during a clear. The bench scenarios cover the behaviour that depends on pin history and timing: the exact synchronizer latency, which edges of each pin count, how the ring option reroutes flag 0, and whether the flags survive a bus reset under each power-management setting.

// File: rtl/sock_chg_pkg.sv
package sock_chg_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FLG_BDEAD = 0;
  localparam int unsigned FLG_BWARN = 1;
  localparam int unsigned FLG_RDY   = 2;
  localparam int unsigned FLG_CDET  = 3;

  // synchronized pin vector layout
  localparam int unsigned NUM_PINS  = 6;
  localparam int unsigned PIN_CD0   = 0;
  localparam int unsigned PIN_CD1   = 1;
  localparam int unsigned PIN_RDY   = 2;
  localparam int unsigned PIN_BWARN = 3;
  localparam int unsigned PIN_BDEAD = 4;
  localparam int unsigned PIN_RING  = 5;

  typedef enum logic {
    CLR_ON_READ = 1'b0,
    CLR_W1C     = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/sock_rst_sync.sv
module sock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sock_pin_sync.sv
module sock_pin_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_a,
  output logic [WIDTH-1:0] pin_s
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= pin_a;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_s = stage_q[STAGES-1];
endmodule

// File: rtl/sock_edge_hist.sv
module sock_edge_hist #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end
endmodule

// File: rtl/sock_chg_reg.sv
module sock_chg_reg
  import sock_chg_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             glob_rst_n,
  input  logic             bus_rst_n,
  input  logic             pme_en,
  input  logic             clr_mode,
  input  logic             io_card,
  input  logic             ring_mode,
  input  logic [3:0]       src_en,
  input  logic [1:0]       cdet_in,
  input  logic             rdy_in,
  input  logic             bwarn_in,
  input  logic             bdead_in,
  input  logic             ring_in,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  localparam int unsigned RSV_W = REG_W - NUM_FLAGS;

  // reset domains: pin path follows global reset, flags follow the combined one
  logic core_rst_n;
  logic flag_rst_n;
  logic flag_arst_n;

  assign flag_arst_n = glob_rst_n & (pme_en | bus_rst_n);

  sock_rst_sync #(.STAGES(RST_STAGES)) i_core_rst (
    .clk(clk), .arst_n(glob_rst_n), .rst_n(core_rst_n)
  );
  sock_rst_sync #(.STAGES(RST_STAGES)) i_flag_rst (
    .clk(clk), .arst_n(flag_arst_n), .rst_n(flag_rst_n)
  );

  // pin synchronization and history
  logic [NUM_PINS-1:0] pin_a;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] pin_p;

  always_comb begin
    pin_a            = '0;
    pin_a[PIN_CD0]   = cdet_in[0];
    pin_a[PIN_CD1]   = cdet_in[1];
    pin_a[PIN_RDY]   = rdy_in;
    pin_a[PIN_BWARN] = bwarn_in;
    pin_a[PIN_BDEAD] = bdead_in;
    pin_a[PIN_RING]  = ring_in;
  end

  sock_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(core_rst_n), .pin_a(pin_a), .pin_s(pin_s)
  );
  sock_edge_hist #(.WIDTH(NUM_PINS)) i_hist (
    .clk(clk), .rst_n(core_rst_n), .cur(pin_s), .prev(pin_p)
  );

  // event detection
  logic [NUM_PINS-1:0]  pin_rise;
  logic [NUM_PINS-1:0]  pin_chg;
  logic [NUM_FLAGS-1:0] evt_raw;
  logic [NUM_FLAGS-1:0] allow;
  logic [NUM_FLAGS-1:0] evt_set;

  always_comb begin
    pin_rise           = pin_s & ~pin_p;
    pin_chg            = pin_s ^ pin_p;
    evt_raw            = '0;
    evt_raw[FLG_CDET]  = pin_chg[PIN_CD0] | pin_chg[PIN_CD1];
    evt_raw[FLG_RDY]   = pin_rise[PIN_RDY];
    evt_raw[FLG_BWARN] = pin_rise[PIN_BWARN];
    evt_raw[FLG_BDEAD] = ring_mode ? pin_rise[PIN_RING] : pin_rise[PIN_BDEAD];
    allow              = src_en;
    if (io_card) begin
      allow[FLG_RDY]   = 1'b0;
      allow[FLG_BWARN] = 1'b0;
    end
    evt_set = evt_raw & allow;
  end

  // clear decode
  clr_mode_e            mode;
  logic [NUM_FLAGS-1:0] clr_vec;

  always_comb begin
    mode    = clr_mode_e'(clr_mode);
    clr_vec = '0;
    if (mode == CLR_ON_READ && rd_stb) clr_vec = '1;
    if (mode == CLR_W1C && wr_stb)     clr_vec = wr_data[NUM_FLAGS-1:0];
  end

  // flag register: next state, enable, storage
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] flags_d;
  logic                 flags_we;

  always_comb begin
    flags_d  = (flags_q & allow & ~clr_vec) | evt_set;
    flags_we = (flags_d != flags_q);
  end

  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n)   flags_q <= '0;
    else if (flags_we) flags_q <= flags_d;
  end

  assign rd_data = {{RSV_W{1'b0}}, flags_q};
  assign irq     = |flags_q;

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[REG_W-1:NUM_FLAGS];

  // ---------------- assertions ----------------
  always_comb begin
    if (flag_rst_n) begin
      assert_reserved_zero_R1: assert (rd_data[REG_W-1:NUM_FLAGS] == '0)
        else $error("reserved bits nonzero");
    end
  end

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag_chk
      assert_disabled_reads_zero_R2: assert property (@(posedge clk) disable iff (!flag_rst_n)
        (!src_en[f] && $past(!src_en[f])) |-> !rd_data[f])
        else $error("disabled flag %0d set", f);
    end
  endgenerate

  assert_io_mask_R5: assert property (@(posedge clk) disable iff (!flag_rst_n)
    (io_card && $past(io_card)) |-> (rd_data[FLG_RDY] == 1'b0 && rd_data[FLG_BWARN] == 1'b0))
    else $error("io-card masked flags set");

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!flag_rst_n)
    (rd_stb && !clr_mode && evt_set == '0) |=> (rd_data[NUM_FLAGS-1:0] == '0))
    else $error("read did not clear");

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!flag_rst_n)
    (wr_stb && clr_mode) |=>
      ((rd_data[NUM_FLAGS-1:0] & $past(wr_data[NUM_FLAGS-1:0] & ~evt_set)) == '0))
    else $error("write-one did not clear");

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!flag_rst_n)
    (evt_set != '0) |=> ((rd_data[NUM_FLAGS-1:0] & $past(evt_set)) == $past(evt_set)))
    else $error("event lost");

  assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!flag_rst_n)
    (rd_stb && !clr_mode && evt_set == '0) |=> !irq)
    else $error("irq held after clear");
endmodule

// File: tb/test_sock_chg_reg.sv
module test_sock_chg_reg;
  logic       clk = 1'b0;
  logic       glob_rst_n, bus_rst_n, pme_en, clr_mode, io_card, ring_mode;
  logic [3:0] src_en;
  logic [1:0] cdet_in;
  logic       rdy_in, bwarn_in, bdead_in, ring_in;
  logic       rd_stb, wr_stb;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sock_chg_reg i_sock_chg_reg (
    .clk(clk), .glob_rst_n(glob_rst_n), .bus_rst_n(bus_rst_n), .pme_en(pme_en),
    .clr_mode(clr_mode), .io_card(io_card), .ring_mode(ring_mode), .src_en(src_en),
    .cdet_in(cdet_in), .rdy_in(rdy_in), .bwarn_in(bwarn_in), .bdead_in(bdead_in),
    .ring_in(ring_in), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // one read strobe cycle; checks the data seen during the strobe
  task automatic do_read(input string req, input logic [7:0] exp);
    rd_stb = 1'b1;
    check(req, rd_data, exp);
    cyc(1);
    rd_stb = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    cyc(1);
    wr_stb = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    check("R9 reset value", rd_data, 8'h00);
    check("R11 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_cdet();
    cdet_in[0] = 1'b1;
    cyc(2);
    check("R12 not yet after two edges", rd_data, 8'h00);
    cyc(1);
    check("R12 set after third edge", rd_data, 8'h08);
    do_read("R6 read shows pre-clear", 8'h08);
    check("R6 cleared after read", rd_data, 8'h00);
    cdet_in[0] = 1'b0;
    cyc(4);
    check("R3 falling cd0 sets", rd_data, 8'h08);
    do_read("R3 read", 8'h08);
    cdet_in[1] = 1'b1;
    cyc(4);
    check("R3 rising cd1 sets", rd_data, 8'h08);
    do_read("R3 read", 8'h08);
    cdet_in[1] = 1'b0;
    cyc(4);
    do_read("R3 falling cd1", 8'h08);
  endtask

  task automatic t_ready();
    rdy_in = 1'b1;
    cyc(4);
    check("R4 rising ready", rd_data, 8'h04);
    do_read("R4 read", 8'h04);
    rdy_in = 1'b0;
    cyc(4);
    check("R4 falling ready ignored", rd_data, 8'h00);
  endtask

  task automatic t_batt();
    bwarn_in = 1'b1;
    cyc(4);
    check("R1 battery warning bit 1", rd_data, 8'h02);
    bdead_in = 1'b1;
    cyc(4);
    check("R8 battery dead bit 0", rd_data, 8'h03);
    check("R11 irq set", {7'b0, irq}, 8'h01);
    do_read("R6 read both", 8'h03);
    check("R11 irq dropped", {7'b0, irq}, 8'h00);
    bwarn_in = 1'b0; bdead_in = 1'b0;
    cyc(4);
    check("R8 falling ignored", rd_data, 8'h00);
  endtask

  task automatic t_ring();
    ring_mode = 1'b1;
    bdead_in = 1'b1;
    cyc(4);
    check("R8 bdead ignored in ring mode", rd_data, 8'h00);
    ring_in = 1'b1;
    cyc(4);
    check("R8 ring sets bit 0", rd_data, 8'h01);
    do_read("R8 read", 8'h01);
    ring_in = 1'b0; bdead_in = 1'b0;
    cyc(4);
    ring_mode = 1'b0;
    check("R8 ring falling ignored", rd_data, 8'h00);
  endtask

  task automatic t_io();
    io_card = 1'b1;
    rdy_in = 1'b1; bwarn_in = 1'b1;
    cyc(4);
    check("R5 io masks ready and warning", rd_data, 8'h00);
    cdet_in[0] = 1'b1;
    cyc(4);
    check("R5 io keeps card detect", rd_data, 8'h08);
    do_read("R5 read", 8'h08);
    rdy_in = 1'b0; bwarn_in = 1'b0; cdet_in[0] = 1'b0;
    cyc(4);
    do_read("R5 cd fall only", 8'h08);
    io_card = 1'b0;
  endtask

  task automatic t_enable();
    bwarn_in = 1'b1;
    cyc(4);
    check("R2 enabled sets", rd_data, 8'h02);
    src_en[1] = 1'b0;
    cyc(1);
    check("R2 disable clears", rd_data, 8'h00);
    src_en[1] = 1'b1;
    cyc(1);
    check("R2 stays clear on re-enable", rd_data, 8'h00);
    bwarn_in = 1'b0;
    cyc(4);
    src_en[1] = 1'b0;
    bwarn_in = 1'b1;
    cyc(4);
    check("R2 disabled event ignored", rd_data, 8'h00);
    src_en = 4'hF;
    bwarn_in = 1'b0;
    cyc(4);
    check("R2 re-enabled no stale", rd_data, 8'h00);
  endtask

  task automatic t_w1c();
    clr_mode = 1'b1;
    cdet_in[0] = 1'b1; bwarn_in = 1'b1;
    cyc(4);
    check("R7 two flags set", rd_data, 8'h0A);
    do_read("R7 read shows flags", 8'h0A);
    check("R7 read does not clear", rd_data, 8'h0A);
    do_write(8'h00);
    check("R7 zero write no effect", rd_data, 8'h0A);
    do_write(8'hF2);
    check("R7 clear bit 1", rd_data, 8'h08);
    check("R11 irq still set", {7'b0, irq}, 8'h01);
    do_write(8'h08);
    check("R7 clear bit 3", rd_data, 8'h00);
    check("R11 irq drops", {7'b0, irq}, 8'h00);
    clr_mode = 1'b0;
    do_write(8'h00);
    cdet_in[0] = 1'b0; bwarn_in = 1'b0;
    cyc(4);
    clr_mode = 1'b0;
    do_write(8'h08);
    check("R6 write ignored in read-clear mode", rd_data, 8'h08);
    do_read("R6 read", 8'h08);
  endtask

  task automatic t_clash();
    bwarn_in = 1'b1;
    cyc(4);
    cdet_in[0] = 1'b1;
    cyc(2);
    rd_stb = 1'b1;
    check("R10 read before clash", rd_data, 8'h02);
    cyc(1);
    rd_stb = 1'b0;
    check("R10 event beats read clear", rd_data, 8'h08);
    clr_mode = 1'b1;
    cdet_in[0] = 1'b0;
    cyc(2);
    do_write(8'h08);
    check("R10 event beats write clear", rd_data, 8'h08);
    do_write(8'h08);
    check("R10 cleared afterwards", rd_data, 8'h00);
    clr_mode = 1'b0;
    bwarn_in = 1'b0;
    cyc(4);
  endtask

  task automatic t_pme();
    bwarn_in = 1'b1;
    cyc(4);
    pme_en = 1'b1;
    bus_rst_n = 1'b0;
    cyc(2);
    bus_rst_n = 1'b1;
    cyc(4);
    check("R9 bus reset ignored with pme", rd_data, 8'h02);
    pme_en = 1'b0;
    bus_rst_n = 1'b0;
    cyc(1);
    check("R9 bus reset clears without pme", rd_data, 8'h00);
    bus_rst_n = 1'b1;
    cyc(4);
    cdet_in[0] = 1'b1;
    cyc(4);
    check("R9 set before global reset", rd_data, 8'h08);
    pme_en = 1'b1;
    glob_rst_n = 1'b0;
    cyc(1);
    check("R9 global reset clears with pme", rd_data, 8'h00);
    cdet_in[0] = 1'b0; bwarn_in = 1'b0;
    cyc(2);
    glob_rst_n = 1'b1;
    cyc(5);
    check("R9 clear after release", rd_data, 8'h00);
    pme_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    glob_rst_n = 1'b0; bus_rst_n = 1'b0; pme_en = 1'b0; clr_mode = 1'b0;
    io_card = 1'b0; ring_mode = 1'b0; src_en = 4'hF; cdet_in = 2'b00;
    rdy_in = 1'b0; bwarn_in = 1'b0; bdead_in = 1'b0; ring_in = 1'b0;
    rd_stb = 1'b0; wr_stb = 1'b0; wr_data = '0;
    cyc(3);
    glob_rst_n = 1'b1; bus_rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_cdet();
    t_ready();
    t_batt();
    t_ring();
    t_io();
    t_enable();
    t_w1c();
    t_clash();
    t_pme();
    summary();
    $finish;
  end
endmodule